// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is a bank of up to 32 general-purpose pins behind a plain 32-bit register bus. Software chooses per pin whether it is a general input, a general output or an interrupt input. Output pins drive a data value with an output enable. Every pin's level is brought into the clock domain through a two-stage synchroniser and can be read back.

An interrupt-mode pin watches its synchronised level with a selectable polarity. It can sense a level, a single edge or both edges. Level events report the current active level. Edge events are latched until software acknowledges them. Pending events pass through a per-pin enable and are ORed into one registered interrupt line.

Both-edge support is a build option. When it is left out, its register reads zero and discards writes.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads 0, every output enable is 0, pin_o is 0 and irq_o is 0. This leaves all pins as positive-logic, level-sensed general inputs with their interrupts disabled.
- R2: Registers sit at these byte offsets: 0x00 mode (1 = interrupt input), 0x04 direction (1 = output), 0x08 output data, 0x0C input data, 0x10 event status, 0x14 acknowledge, 0x18 enable-AND, 0x1C enable-set, 0x20 polarity (1 = active low / falling), 0x24 trigger (1 = edge, 0 = level) and 0x4C both-edge. Bit n belongs to pin n. Bits at or above NUM_PINS read 0, and reads of the acknowledge and enable-set offsets return 0.
- R3: A pin's output enable is 1 only when its mode bit is 0 and its direction bit is 1. pin_o carries the output data register.
- R4: The input data register returns the pin levels two clock edges after they are applied.
- R5: An interrupt pin in level mode shows status 1 exactly while its synchronised level, XORed with its polarity bit, is 1.
- R6: In single-edge mode, a pin latches status 1 on a rising edge (polarity 0) or a falling edge (polarity 1) of its synchronised level. The latched bit holds until it is acknowledged.
- R7: With BOTH_EDGE_EN=1, a pin with its both-edge bit and its trigger bit set latches on either transition. With BOTH_EDGE_EN=0, the both-edge register reads 0, ignores writes and never widens detection.
- R8: Writing 1 to an acknowledge bit clears that pin's latched edge status, and bits written 0 leave status unchanged. An acknowledge has no lasting effect on a level-mode pin whose level is still active.
- R9: If an edge is detected on the same clock edge as its acknowledge, the status stays 1.
- R10: A write to 0x18 keeps a pin enabled only where the written bit is 1. A write of 1 to a bit of 0x1C enables that pin. Reading 0x18 returns 1 for enabled pins.
- R11: irq_o is 1 exactly one clock edge after the AND of status and enable is nonzero.
- R12: A pin whose mode bit is 0 reports status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle as the access, 0 when no read |
| pin_i | input | NUM_PINS | Pin levels, asynchronous |
| pin_o | output | NUM_PINS | Output data |
| pin_oe_o | output | NUM_PINS | Output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds two instances. The first has NUM_PINS=4 with both-edge support. With so few pins, every sensing mode can be swept through sixteen pin patterns, which covers every one-pin transition type under two alternating enable masks. The second has NUM_PINS=3 with both-edge support left out. It exposes the tied-off register, the zero upper read bits and single-edge detection with the both-edge bit written. Exact edge timing is used to place an acknowledge on the same edge as a new event and one edge after it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned BUS_AW = 8;

  localparam logic [BUS_AW-1:0] OFF_MODE   = 8'h00;
  localparam logic [BUS_AW-1:0] OFF_DIR    = 8'h04;
  localparam logic [BUS_AW-1:0] OFF_DOUT   = 8'h08;
  localparam logic [BUS_AW-1:0] OFF_DIN    = 8'h0C;
  localparam logic [BUS_AW-1:0] OFF_STAT   = 8'h10;
  localparam logic [BUS_AW-1:0] OFF_ACK    = 8'h14;
  localparam logic [BUS_AW-1:0] OFF_EN_AND = 8'h18;
  localparam logic [BUS_AW-1:0] OFF_EN_SET = 8'h1C;
  localparam logic [BUS_AW-1:0] OFF_POL    = 8'h20;
  localparam logic [BUS_AW-1:0] OFF_TRIG   = 8'h24;
  localparam logic [BUS_AW-1:0] OFF_BOTH   = 8'h4C;

  typedef struct packed {
    logic irq_mode;
    logic neg;
    logic edge_sel;
    logic both;
  } sense_cfg_t;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS     = 32,
  parameter bit          BOTH_EDGE_EN = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [BUS_AW-1:0]   addr_i,
  input  logic [BUS_DW-1:0]   wdata_i,
  output logic [BUS_DW-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] din_i,
  input  logic [NUM_PINS-1:0] stat_i,
  output logic [NUM_PINS-1:0] mode_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] dout_o,
  output logic [NUM_PINS-1:0] pol_o,
  output logic [NUM_PINS-1:0] trig_o,
  output logic [NUM_PINS-1:0] both_o,
  output logic [NUM_PINS-1:0] en_o,
  output logic [NUM_PINS-1:0] ack_o
);
  logic                wr;
  logic [NUM_PINS-1:0] wbits;
  logic [NUM_PINS-1:0] mode_q, dir_q, dout_q, pol_q, trig_q, en_q;
  logic [NUM_PINS-1:0] rd_bits;

  assign wr    = req_i & we_i;
  assign wbits = wdata_i[NUM_PINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      dir_q  <= '0;
      dout_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
      en_q   <= '0;
    end else if (wr) begin
      case (addr_i)
        OFF_MODE:   mode_q <= wbits;
        OFF_DIR:    dir_q  <= wbits;
        OFF_DOUT:   dout_q <= wbits;
        OFF_POL:    pol_q  <= wbits;
        OFF_TRIG:   trig_q <= wbits;
        OFF_EN_AND: en_q   <= en_q & wbits;
        OFF_EN_SET: en_q   <= en_q | wbits;
        default: ;
      endcase
    end
  end

  if (BOTH_EDGE_EN) begin : g_both
    logic [NUM_PINS-1:0] both_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        both_q <= '0;
      else if (wr && addr_i == OFF_BOTH)  both_q <= wbits;
    end
    assign both_o = both_q;
  end else begin : g_no_both
    assign both_o = '0;
  end

  assign ack_o = (wr && addr_i == OFF_ACK) ? wbits : '0;

  always_comb begin
    rd_bits = '0;
    if (req_i && !we_i) begin
      case (addr_i)
        OFF_MODE:   rd_bits = mode_q;
        OFF_DIR:    rd_bits = dir_q;
        OFF_DOUT:   rd_bits = dout_q;
        OFF_DIN:    rd_bits = din_i;
        OFF_STAT:   rd_bits = stat_i;
        OFF_EN_AND: rd_bits = en_q;
        OFF_POL:    rd_bits = pol_q;
        OFF_TRIG:   rd_bits = trig_q;
        OFF_BOTH:   rd_bits = both_o;
        default:    rd_bits = '0;
      endcase
    end
    rdata_o = '0;
    rdata_o[NUM_PINS-1:0] = rd_bits;
  end

  assign mode_o = mode_q;
  assign dir_o  = dir_q;
  assign dout_o = dout_q;
  assign pol_o  = pol_q;
  assign trig_o = trig_q;
  assign en_o   = en_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] mode_i,
  input  logic [NUM_PINS-1:0] pol_i,
  input  logic [NUM_PINS-1:0] trig_i,
  input  logic [NUM_PINS-1:0] both_i,
  input  logic [NUM_PINS-1:0] ack_i,
  output logic [NUM_PINS-1:0] stat_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    sense_cfg_t cfg;
    logic prev_q, latch_q;
    logic act, act_prev, hit, fire;

    assign cfg      = '{irq_mode: mode_i[p], neg: pol_i[p], edge_sel: trig_i[p], both: both_i[p]};
    assign act      = lvl_i[p] ^ cfg.neg;
    assign act_prev = prev_q ^ cfg.neg;
    assign hit      = cfg.both ? (act ^ act_prev) : (act & ~act_prev);
    assign fire     = cfg.irq_mode & cfg.edge_sel & hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q  <= 1'b0;
        latch_q <= 1'b0;
      end else begin
        prev_q <= lvl_i[p];
        // a fresh edge outranks a simultaneous acknowledge
        if (fire)          latch_q <= 1'b1;
        else if (ack_i[p]) latch_q <= 1'b0;
      end
    end

    assign stat_o[p] = cfg.irq_mode & (cfg.edge_sel ? latch_q : act);
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS     = 32,
  parameter bit          BOTH_EDGE_EN = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [7:0]          addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] lvl_w, mode_w, dir_w, dout_w, pol_w, trig_w, both_w, en_w, ack_w, stat_w;
  logic                irq_q;

  gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(2)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl_w)
  );

  gpio_irq_regs #(.NUM_PINS(NUM_PINS), .BOTH_EDGE_EN(BOTH_EDGE_EN)) regs_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .din_i  (lvl_w),
    .stat_i (stat_w),
    .mode_o (mode_w),
    .dir_o  (dir_w),
    .dout_o (dout_w),
    .pol_o  (pol_w),
    .trig_o (trig_w),
    .both_o (both_w),
    .en_o   (en_w),
    .ack_o  (ack_w)
  );

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) detect_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl_w),
    .mode_i(mode_w),
    .pol_i (pol_w),
    .trig_i(trig_w),
    .both_i(both_w),
    .ack_i (ack_w),
    .stat_o(stat_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(stat_w & en_w);
  end

  assign pin_o    = dout_w;
  assign pin_oe_o = dir_w & ~mode_w;
  assign irq_o    = irq_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [7:0]          addr_i,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] mode_w,
  input logic [NUM_PINS-1:0] stat_w,
  input logic [NUM_PINS-1:0] en_w
);
  // R11
  irq_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(stat_w & en_w)));

  // R3
  oe_gpio_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & mode_w) == '0);

  // R12
  stat_irq_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_w & ~mode_w) == '0);

  // R10
  en_and_shrinks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFF_EN_AND) |=> ((en_w & ~$past(en_w)) == '0));

  // R10
  en_set_grows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFF_EN_SET) |=> (($past(en_w) & ~en_w) == '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .pin_oe_o(pin_oe_o),
  .irq_o   (irq_o),
  .mode_w  (mode_w),
  .stat_w  (stat_w),
  .en_w    (en_w)
);

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_a = 0, req_b = 0, we = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic [3:0]  pins_a = '0, pout_a, oe_a;
  logic [2:0]  pins_b = '0, pout_b, oe_b;
  logic        irq_a, irq_b;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  gpio_irq_bank #(.NUM_PINS(4), .BOTH_EDGE_EN(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_a), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_a), .pin_i(pins_a), .pin_o(pout_a),
    .pin_oe_o(oe_a), .irq_o(irq_a));

  gpio_irq_bank #(.NUM_PINS(3), .BOTH_EDGE_EN(1'b0)) dut_nb_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_b), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_b), .pin_i(pins_b), .pin_o(pout_b),
    .pin_oe_o(oe_b), .irq_o(irq_b));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic wr(input bit b, input logic [7:0] a, input logic [31:0] d);
    if (b) req_b = 1; else req_a = 1;
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    req_a = 0; req_b = 0; we = 0;
  endtask

  task automatic rd(input bit b, input logic [7:0] a, output logic [31:0] d);
    if (b) req_b = 1; else req_a = 1;
    we = 0; addr = a;
    #1 d = b ? rdata_b : rdata_a;
    req_a = 0; req_b = 0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [3:0] prevv, lat, a, ap, exp, mm, pol, trig, both;
    logic [7:0] offs [11];
    offs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h4C};

    idle(3);
    rst_n = 1;
    idle(2);

    // R1 reset state
    for (int i = 0; i < 11; i++) begin
      rd(0, offs[i], r); chk("R1 reset read", r, 0);
    end
    chk("R1 oe", {28'd0, oe_a}, 0);
    chk("R1 pin_o", {28'd0, pout_a}, 0);
    chk("R1 irq", {31'd0, irq_a}, 0);

    // R2 readback and unused bits
    wr(0, 8'h24, 32'hFFFF_FFF5); rd(0, 8'h24, r); chk("R2 trig readback", r, 32'h5);
    wr(0, 8'h20, 32'h0000_000A); rd(0, 8'h20, r); chk("R2 pol readback", r, 32'hA);
    wr(0, 8'h4C, 32'h0000_0003); rd(0, 8'h4C, r); chk("R2 both readback", r, 32'h3);
    wr(1, 8'h00, 32'hFFFF_FFFF); rd(1, 8'h00, r); chk("R2 upper bits zero", r, 32'h7);
    wr(1, 8'h00, 0);
    wr(0, 8'h1C, 32'hF); rd(0, 8'h1C, r); chk("R2 enable-set reads 0", r, 0);
    rd(0, 8'h14, r); chk("R2 ack reads 0", r, 0);
    wr(0, 8'h24, 0); wr(0, 8'h20, 0); wr(0, 8'h4C, 0);

    // R10 enable registers
    wr(0, 8'h18, 0);    rd(0, 8'h18, r); chk("R10 and-0 disables all", r, 0);
    wr(0, 8'h1C, 4'hB); rd(0, 8'h18, r); chk("R10 set enables", r, 4'hB);
    wr(0, 8'h18, 4'h6); rd(0, 8'h18, r); chk("R10 and keeps ones", r, 4'h2);
    wr(0, 8'h1C, 4'h0); rd(0, 8'h18, r); chk("R10 set zero no effect", r, 4'h2);
    wr(0, 8'h18, 0);

    // R3 outputs
    wr(0, 8'h08, 4'hA); wr(0, 8'h04, 4'h3);
    chk("R3 oe gpio out", {28'd0, oe_a}, 4'h3);
    chk("R3 pin_o data", {28'd0, pout_a}, 4'hA);
    wr(0, 8'h00, 4'h1);
    chk("R3 oe off in irq mode", {28'd0, oe_a}, 4'h2);
    wr(0, 8'h00, 0); wr(0, 8'h04, 0);

    // R4 input latency
    pins_a = 4'h9;
    idle(1);
    rd(0, 8'h0C, r); chk("R4 one edge not yet", r, 0);
    rd(0, 8'h0C, r); chk("R4 after two edges", r, 4'h9);

    // R12 status zero in gpio mode (level-active under positive logic)
    rd(0, 8'h10, r); chk("R12 gpio mode status", r, 0);
    pins_a = 0; idle(4);

    // Sweep modes: 0 lvl-hi, 1 lvl-lo, 2 rise, 3 fall, 4 both
    prevv = 0;
    for (int m = 0; m < 5; m++) begin
      pol  = (m == 1 || m == 3) ? 4'hF : 4'h0;
      trig = (m >= 2) ? 4'hF : 4'h0;
      both = (m == 4) ? 4'hF : 4'h0;
      mm   = (m % 2) ? 4'hA : 4'h5;
      wr(0, 8'h20, {28'd0, pol});
      wr(0, 8'h24, {28'd0, trig});
      wr(0, 8'h4C, {28'd0, both});
      wr(0, 8'h00, 4'hF);
      wr(0, 8'h14, 4'hF);
      wr(0, 8'h18, 0);
      wr(0, 8'h1C, {28'd0, mm});
      lat = 0;
      for (int s = 0; s < 16; s++) begin
        logic [3:0] v;
        v = 4'((s * 7 + 3) % 16);
        pins_a = v;
        idle(4);
        a  = v ^ pol;
        ap = prevv ^ pol;
        if (m >= 2) begin
          lat = lat | ((m == 4) ? (a ^ ap) : (a & ~ap));
          exp = lat;
        end else exp = a;
        rd(0, 8'h10, r);
        if (m < 2)       chk("R5 level status", r, {28'd0, exp});
        else if (m == 4) chk("R7 both-edge status", r, {28'd0, exp});
        else             chk("R6 single-edge status", r, {28'd0, exp});
        chk("R11 irq", {31'd0, irq_a}, {31'd0, |(exp & mm)});
        wr(0, 8'h14, 4'hF);
        lat = 0;
        if (m < 2) begin
          rd(0, 8'h10, r); chk("R8 ack no effect on level", r, {28'd0, a});
        end else begin
          rd(0, 8'h10, r); chk("R8 ack clears edge", r, 0);
        end
        prevv = v;
      end
    end

    // R8 partial acknowledge, rising mode
    wr(0, 8'h4C, 0); wr(0, 8'h20, 0); wr(0, 8'h24, 4'hF);
    pins_a = 0; idle(4); wr(0, 8'h14, 4'hF);
    pins_a = 4'hF; idle(4);
    wr(0, 8'h14, 4'h5);
    rd(0, 8'h10, r); chk("R8 zero bits keep status", r, 4'hA);
    wr(0, 8'h14, 4'hF);

    // R9 edge on same edge as acknowledge
    pins_a = 4'h0; idle(4);
    pins_a = 4'h1; idle(2);
    wr(0, 8'h14, 4'h1);
    rd(0, 8'h10, r); chk("R9 edge beats ack", r, 4'h1);
    wr(0, 8'h14, 4'hF);
    pins_a = 4'h3; idle(3);
    wr(0, 8'h14, 4'h2);
    rd(0, 8'h10, r); chk("R9 later ack clears", r, 0);

    // R7 without both-edge support
    wr(1, 8'h4C, 4'h7); rd(1, 8'h4C, r); chk("R7 absent reg reads 0", r, 0);
    wr(1, 8'h24, 4'h7); wr(1, 8'h00, 4'h7); wr(1, 8'h14, 4'h7);
    pins_b = 3'h5; idle(4);
    rd(1, 8'h10, r); chk("R7 rise detected", r, 4'h5);
    wr(1, 8'h14, 4'h7);
    pins_b = 3'h0; idle(4);
    rd(1, 8'h10, r); chk("R7 fall ignored", r, 0);

    finish_run();
  end
endmodule